// File: doc/BRIEF.md
# Cascaded Two-Stage Priority Interrupt Controller

This block joins two eight-input priority interrupt controllers into one primary/secondary pair that serves a single processor. The secondary controller's request output enters primary input 2, so fifteen of the sixteen request inputs are usable. Input 2 of the request bus is taken by the cascade and is not used as a request. Requests are edge-sensitive. A per-line mask decides which edges are latched and which pending requests are presented. The block raises one interrupt line. When the processor acknowledges, it returns an 8-bit vector made from a programmable 5-bit base and the 3-bit line number within the controller that won.

In-service state is kept per controller, so a more urgent request can interrupt a less urgent handler while a less urgent request waits. Software retires a handler with an end-of-interrupt command sent to the controller concerned. A handler for a secondary line needs one command to each controller.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_vld` are low and all sixteen mask bits are set, so a request edge arriving before software unmasks anything raises nothing.
- R2: A request is latched on a rising edge of its input. Holding an input high after its request has been acknowledged and retired raises no further request until the input falls and rises again.
- R3: Configuration address 0 writes the 16-bit mask, where bit n masks line n. An edge on a masked line is dropped. A latched request whose line is masked later is withheld and is presented again once the line is unmasked. Mask bit 2 withholds every secondary line.
- R4: Request input bit 2 has no effect. Its edges never raise `int_out`, and an acknowledge after such an edge returns nothing.
- R5: Among pending unmasked requests, the order from most to least urgent is line 0, line 1, lines 8 to 15 in ascending order, then lines 3 to 7 in ascending order.
- R6: Configuration address 1 writes the primary base and address 2 writes the secondary base, each in data bits 4:0. A vector for line n below 8 is {primary base, n[2:0]}. A vector for line n from 8 up is {secondary base, (n-8)[2:0]}.
- R7: An acknowledge while `int_out` is high sets `vec_vld` for exactly the following cycle, with the winner's vector on `vec_out`. It clears the winner's request and marks it in service. For a secondary line, the secondary line and the primary cascade input are both marked in service.
- R8: `int_out` is high only when the most urgent presented request outranks every in-service line of its controller. A secondary line counts as primary line 2, so a secondary request cannot interrupt a handler for another secondary line.
- R9: `eoi_pri` clears the most urgent in-service bit of the primary controller, and `eoi_sec` does the same for the secondary controller.
- R10: An acknowledge while `int_out` is low is ignored. `vec_vld` stays low and the state is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines, edge-sensitive; bit 2 unused |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 mask, 1 primary base, 2 secondary base |
| cfg_wdata | input | 16 | Configuration write data |
| ack | input | 1 | Processor acknowledge strobe |
| eoi_pri | input | 1 | End-of-interrupt to the primary controller |
| eoi_sec | input | 1 | End-of-interrupt to the secondary controller |
| int_out | output | 1 | Interrupt request to the processor |
| vec_vld | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec_out | output | 8 | Returned vector |

## Verification
Every usable line is raised alone to confirm its vector and to confirm that handling it leaves no request behind. Every unordered pair is raised in the same cycle, which shows whether the arbitration follows the cascaded order or plain numeric order. Every ordered pair is then raised one after the other with the first still in service. The expected outcome is worked out from ranks in the bench. This separates a correct preemption from one that ignores the cascade blocking between secondary lines. Directed cases cover masking before and after latching, the cascade mask bit, held-high inputs, the unused input, a stray acknowledge, and which in-service bit an end-of-interrupt command clears.

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl #(
  parameter int CASC_LINE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        ack,
  input  logic        eoi_pri,
  input  logic        eoi_sec,
  output logic        int_out,
  output logic        vec_vld,
  output logic [7:0]  vec_out
);
  localparam logic [2:0] CID  = 3'(CASC_LINE);
  localparam logic [7:0] CBIT = 8'd1 << CASC_LINE;

  logic [15:0] irq_q, irr, mask;
  logic [4:0]  p_base, s_base;
  logic [7:0]  p_isr, s_isr;

  function automatic logic [3:0] first1(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = {1'b1, 3'(i)};
    return r;
  endfunction

  logic [15:0] rise;
  logic [7:0]  s_pend, p_pend;
  logic [3:0]  s_req, s_srv, p_req, p_srv;
  logic        s_int, take, to_sec;
  logic [15:0] clr;
  logic [7:0]  p_set, s_set, p_eclr, s_eclr;

  assign rise   = irq_in & ~irq_q & ~mask & ~{8'h00, CBIT};
  assign s_pend = irr[15:8] & ~mask[15:8];
  assign s_req  = first1(s_pend);
  assign s_srv  = first1(s_isr);
  assign s_int  = s_req[3] && (!s_srv[3] || s_req[2:0] < s_srv[2:0]);
  assign p_pend = (irr[7:0] & ~mask[7:0] & ~CBIT) |
                  ((s_int && !mask[CASC_LINE]) ? CBIT : 8'h00);
  assign p_req  = first1(p_pend);
  assign p_srv  = first1(p_isr);
  assign int_out = p_req[3] && (!p_srv[3] || p_req[2:0] < p_srv[2:0]);

  assign take   = ack && int_out;
  assign to_sec = (p_req[2:0] == CID);
  assign clr    = !take ? 16'h0 :
                  to_sec ? (16'd1 << (8 + int'(s_req[2:0]))) : (16'd1 << p_req[2:0]);
  assign p_set  = take ? (8'd1 << p_req[2:0]) : 8'h00;
  assign s_set  = (take && to_sec) ? (8'd1 << s_req[2:0]) : 8'h00;
  assign p_eclr = (eoi_pri && p_srv[3]) ? (8'd1 << p_srv[2:0]) : 8'h00;
  assign s_eclr = (eoi_sec && s_srv[3]) ? (8'd1 << s_srv[2:0]) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= '0;
      irr     <= '0;
      mask    <= '1;
      p_base  <= '0;
      s_base  <= '0;
      p_isr   <= '0;
      s_isr   <= '0;
      vec_vld <= 1'b0;
      vec_out <= '0;
    end else begin
      irq_q   <= irq_in;
      irr     <= (irr | rise) & ~clr;
      p_isr   <= (p_isr & ~p_eclr) | p_set;
      s_isr   <= (s_isr & ~s_eclr) | s_set;
      vec_vld <= take;
      if (take)
        vec_out <= to_sec ? {s_base, s_req[2:0]} : {p_base, p_req[2:0]};
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: mask   <= cfg_wdata;
          2'd1: p_base <= cfg_wdata[4:0];
          2'd2: s_base <= cfg_wdata[4:0];
          default: ;
        endcase
      end
    end
  end

  // R2: a request bit appears only after a rising input edge
  a_r2_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~$past(irr)) & ~($past(irq_in) & ~$past(irq_q))) == 16'h0);

  // R7: vector valid only after an accepted acknowledge
  a_r7_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_vld) |-> $past(ack) && $past(int_out));

  // R7: accepted acknowledge adds in-service state
  a_r7_isr_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eoi_pri && !eoi_sec) |=>
      ($countones(p_isr) + $countones(s_isr)) > $past($countones(p_isr) + $countones(s_isr)));

  // R8: interrupt only with some unmasked pending request
  a_r8_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~mask) != 16'h0);

  // R9: primary end-of-interrupt clears exactly one bit
  a_r9_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pri && p_isr != 8'h00 && !take) |=> $countones(p_isr) == $past($countones(p_isr)) - 1);

  // R6: returned vector carries one of the programmed bases
  a_r6_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> (vec_out[7:3] == $past(p_base) || vec_out[7:3] == $past(s_base)));
endmodule

// File: tb/sim_cascaded_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cascaded_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq_v = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic ack = 1'b0, eoi_pri = 1'b0, eoi_sec = 1'b0;
  logic int_out, vec_vld;
  logic [7:0] vec_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] PB = 5'h08;
  localparam logic [4:0] SB = 5'h0E;

  always #2 clk = ~clk;

  cascaded_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_v), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ack(ack), .eoi_pri(eoi_pri), .eoi_sec(eoi_sec),
    .int_out(int_out), .vec_vld(vec_vld), .vec_out(vec_out));

  function automatic int rank(input int n);
    if (n < 2) return n;
    if (n >= 8) return n - 6;
    return n + 7;
  endfunction

  function automatic logic [7:0] vexp(input int n);
    if (n < 8) return {PB, 3'(n)};
    return {SB, 3'(n - 8)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] lines);
    irq_v = irq_v | lines; tick(); irq_v = irq_v & ~lines;
  endtask

  task automatic do_ack(output logic [7:0] v, output logic vv);
    ack = 1'b1; tick(); ack = 1'b0; v = vec_out; vv = vec_vld;
  endtask

  task automatic retire(input int n);
    if (n >= 8) begin eoi_sec = 1'b1; tick(); eoi_sec = 1'b0; end
    eoi_pri = 1'b1; tick(); eoi_pri = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    logic vv;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 int_out after reset", int_out, 0);
    chk("R1 vec_vld after reset", vec_vld, 0);
    pulse(16'h0001);
    chk("R1 reset mask blocks", int_out, 0);
    cfg(2'd0, 16'h0000);
    chk("R3 dropped masked edge", int_out, 0);
    cfg(2'd1, {11'd0, PB});
    cfg(2'd2, {11'd0, SB});

    do_ack(v, vv);
    chk("R10 stray ack vld", vv, 0);
    chk("R10 stray ack int", int_out, 0);

    pulse(16'h0004);
    chk("R4 line 2 int", int_out, 0);
    do_ack(v, vv);
    chk("R4 line 2 ack", vv, 0);

    for (int n = 0; n < 16; n++) begin
      if (n == 2) continue;
      pulse(16'd1 << n);
      chk("R2 single raise", int_out, 1);
      do_ack(v, vv);
      chk("R7 single vld", vv, 1);
      chk("R6 single vector", v, vexp(n));
      chk("R7 single int cleared", int_out, 0);
      retire(n);
      chk("R9 single retired", int_out, 0);
    end

    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++) begin
        int w, l;
        if (a == 2 || b == 2) continue;
        w = rank(a) < rank(b) ? a : b;
        l = (w == a) ? b : a;
        pulse((16'd1 << a) | (16'd1 << b));
        do_ack(v, vv);
        chk("R5 pair winner", v, vexp(w));
        chk("R8 loser waits", int_out, 0);
        retire(w);
        chk("R5 loser pending", int_out, 1);
        do_ack(v, vv);
        chk("R5 pair loser", v, vexp(l));
        retire(l);
      end

    for (int lo = 0; lo < 16; lo++)
      for (int hi = 0; hi < 16; hi++) begin
        bit pre;
        if (lo == 2 || hi == 2 || lo == hi) continue;
        pre = (rank(hi) < rank(lo)) && !(hi >= 8 && lo >= 8);
        pulse(16'd1 << lo);
        do_ack(v, vv);
        chk("R6 first vector", v, vexp(lo));
        pulse(16'd1 << hi);
        chk("R8 preempt decision", int_out, 32'(pre));
        if (pre) begin
          do_ack(v, vv);
          chk("R8 nested vector", v, vexp(hi));
          retire(hi);
          chk("R9 outer still in service", int_out, 0);
          retire(lo);
        end else begin
          retire(lo);
          chk("R8 deferred raise", int_out, 1);
          do_ack(v, vv);
          chk("R8 deferred vector", v, vexp(hi));
          retire(hi);
        end
        chk("R9 all retired", int_out, 0);
      end

    pulse(16'h0020);
    cfg(2'd0, 16'h0020);
    chk("R3 latched then masked", int_out, 0);
    cfg(2'd0, 16'h0000);
    chk("R3 unmask presents", int_out, 1);
    do_ack(v, vv);
    chk("R3 unmasked vector", v, vexp(5));
    retire(5);

    cfg(2'd0, 16'h0004);
    pulse(16'h0200);
    chk("R3 cascade mask", int_out, 0);
    pulse(16'h0010);
    do_ack(v, vv);
    chk("R3 primary past cascade mask", v, vexp(4));
    retire(4);
    cfg(2'd0, 16'h0000);
    chk("R3 cascade unmasked", int_out, 1);
    do_ack(v, vv);
    chk("R3 secondary after unmask", v, vexp(9));
    retire(9);

    irq_v[4] = 1'b1; tick();
    chk("R2 level raise", int_out, 1);
    do_ack(v, vv);
    retire(4);
    repeat (3) tick();
    chk("R2 held level no repeat", int_out, 0);
    irq_v[4] = 1'b0; tick();
    irq_v[4] = 1'b1; tick();
    chk("R2 new edge", int_out, 1);
    do_ack(v, vv);
    retire(4);
    irq_v[4] = 1'b0; tick();

    pulse(16'h0020);
    do_ack(v, vv);
    pulse(16'h0008);
    do_ack(v, vv);
    chk("R8 line 3 over 5", v, vexp(3));
    retire(3);
    pulse(16'h0010);
    chk("R9 eoi cleared most urgent", int_out, 1);
    do_ack(v, vv);
    chk("R9 line 4 vector", v, vexp(4));
    retire(4);
    retire(5);
    chk("R9 final idle", int_out, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule